// File: doc/BRIEF.md
# Square-Wave NCO Driver for a Ground-Switching Mixer

This block is a numerically controlled oscillator whose only product is a square wave. A phase accumulator adds a held tuning word on every clock. The accumulator's most significant bit is the local-oscillator square wave. No sine samples are produced.

That bit is turned into two registered clamp enables that are complements of each other. Each enable drives the enable of a tri-state pad buffer whose data is tied low. While an enable is high, its signal path is pulled to ground. While it is low, the buffer floats and the signal passes through. Swapping the two enables every half LO period makes a synchronous modulator.

The LO is usually programmed to the wanted signal frequency plus a 200 kHz offset. The output frequency is `W * f_clk / 2^32`, so the highest useful LO is set by the fabric clock. A new tuning word is written with a one-cycle load strobe. Phase is never reset on a load, so the square wave continues without a glitch.

Top module: `sqwave_mixer_drv`

## Requirements
- R1: Reset is synchronous and active low (`rstN` sampled on the rising clock edge). While in reset, and on the first edge after reset is released, both `clampEnA` and `clampEnB` are 0, meaning both paths pass.
- R2: From the second edge after reset release onward, `clampEnB` is always the logical complement of `clampEnA`, and the two outputs change on the same edge.
- R3: From the second edge after release, `clampEnA` after an edge equals bit 31 (the sign bit) of the accumulator value held before that edge. The accumulator is 0 after reset.
- R4: From the second edge after release, the accumulator adds the held tuning word on every edge, modulo 2^32. A held word of 0 freezes the accumulator, so both enables stay constant.
- R5: `tuneWord` is captured on an edge where `tuneLoad` is 1. The accumulator first adds the new word on the following edge. After reset, the held word is 0.
- R6: Loading a word does not clear or change the accumulator phase. The accumulator keeps its value and only its step size changes.
- R7: While `tuneLoad` is 0, changes on `tuneWord` have no effect on the outputs.
- R8: For a held word of 2^k, `clampEnA` has a period of 2^(32-k) clocks with equal high and low time. For example, 2^27 gives a 32-clock period, and 2^31 toggles on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Synchronous active-low reset |
| tuneWord | input | 32 | Phase increment per clock |
| tuneLoad | input | 1 | One-cycle strobe that captures `tuneWord` |
| clampEnA | output | 1 | Buffer enable for path A; 1 clamps the path to ground |
| clampEnB | output | 1 | Buffer enable for path B; always the complement of `clampEnA` once running |

## Verification
A power-of-two word of 2^27 and the half-scale word 2^31 check the period and duty cycle exactly. These two words tell a correct sign-bit tap apart from an off-by-one bit choice or a late carry. A word of zero shows that the accumulator freezes. Changing `tuneWord` with no strobe shows whether the input is ignored as required. Loads in mid-phase, a reset in mid-run and a long run of random words with random load strobes are compared every clock against a behavioural reference. That comparison exposes any phase reset on load, a wrong capture latency, or a pair of enables that are not complementary.

// File: rtl/sqwave_mixer_pkg.sv
package sqwave_mixer_pkg;

  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic capture;  // take a new tuning word
    logic step;     // advance the phase accumulator
    logic drive;    // refresh the clamp enable registers
  } nco_strobe_t;

endpackage

// File: rtl/sqwave_mixer_ctrl.sv
module sqwave_mixer_ctrl
  import sqwave_mixer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tuneLoad,
  output nco_strobe_t strobe
);

  // Goes high on the first edge after reset release
  logic liveQ;

  always_ff @(posedge clk) begin
    if (!rstN) liveQ <= 1'b0;
    else       liveQ <= 1'b1;
  end

  always_comb begin
    strobe.capture = tuneLoad;
    strobe.step    = liveQ;
    strobe.drive   = liveQ;
  end

endmodule

// File: rtl/sqwave_mixer_dp.sv
module sqwave_mixer_dp
  import sqwave_mixer_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  nco_strobe_t      strobe,
  input  logic [ACC_W-1:0] tuneWord,
  output logic             clampEnA,
  output logic             clampEnB
);

  localparam int SIGN_BIT = ACC_W - 1;

  logic [ACC_W-1:0] tuneQ;
  logic [ACC_W-1:0] phaseQ;
  logic             loSign;

  assign loSign = phaseQ[SIGN_BIT];

  // Held tuning word
  always_ff @(posedge clk) begin
    if (!rstN)               tuneQ <= '0;
    else if (strobe.capture) tuneQ <= tuneWord;
  end

  // Phase accumulator, never cleared by a load
  always_ff @(posedge clk) begin
    if (!rstN)            phaseQ <= '0;
    else if (strobe.step) phaseQ <= phaseQ + tuneQ;
  end

  // Registered complementary enables; both released in reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clampEnA <= 1'b0;
      clampEnB <= 1'b0;
    end else if (strobe.drive) begin
      clampEnA <= loSign;
      clampEnB <= ~loSign;
    end
  end

endmodule

// File: rtl/sqwave_mixer_drv.sv
module sqwave_mixer_drv
  import sqwave_mixer_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ACC_W-1:0] tuneWord,
  input  logic             tuneLoad,
  output logic             clampEnA,
  output logic             clampEnB
);

  nco_strobe_t strobe;

  sqwave_mixer_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tuneLoad (tuneLoad),
    .strobe   (strobe)
  );

  sqwave_mixer_dp #(.ACC_W(ACC_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tuneWord (tuneWord),
    .clampEnA (clampEnA),
    .clampEnB (clampEnB)
  );

endmodule

// File: rtl/sqwave_mixer_drv_chk.sv
module sqwave_mixer_drv_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [ACC_W-1:0] tuneWord,
  input logic             tuneLoad,
  input logic             clampEnA,
  input logic             clampEnB
);

  localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!clampEnA && !clampEnB));

  // R1
  first_live_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(rstN, 2)) |-> (!clampEnA && !clampEnB));

  // R2
  complement_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2)) |-> (clampEnA != clampEnB));

  // R5
  half_word_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && $past(rstN, 3) &&
     $past(tuneLoad, 3) && ($past(tuneWord, 3) == HALF))
    |-> (clampEnA != $past(clampEnA)));

endmodule

bind sqwave_mixer_drv sqwave_mixer_drv_chk #(.ACC_W(ACC_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .tuneWord (tuneWord),
  .tuneLoad (tuneLoad),
  .clampEnA (clampEnA),
  .clampEnB (clampEnB)
);

// File: tb/sqwave_mixer_drv_test.sv
`timescale 1ns/1ps
module sqwave_mixer_drv_test;

  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] tuneWord = '0;
  logic        tuneLoad = 1'b0;
  logic        clampEnA;
  logic        clampEnB;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";

  // Behavioural reference state
  longint refTune = 0;
  longint refAcc  = 0;
  int     refLive = 0;
  int     refA    = 0;
  int     refB    = 0;
  int     liveEdges = 0;

  sqwave_mixer_drv uut (
    .clk(clk), .rstN(rstN), .tuneWord(tuneWord), .tuneLoad(tuneLoad),
    .clampEnA(clampEnA), .clampEnB(clampEnB)
  );

  always #(CLK_NS/2) clk = ~clk;

  // Reference model: updated on each rising edge from the sampled inputs
  always @(posedge clk) begin
    longint nTune, nAcc;
    int nA, nB, nLive, sgn;
    if (!rstN) begin
      refTune = 0; refAcc = 0; refLive = 0; refA = 0; refB = 0; liveEdges = 0;
    end else begin
      sgn   = (refAcc >= 64'd2147483648) ? 1 : 0;
      nTune = tuneLoad ? longint'(tuneWord) : refTune;
      nAcc  = refLive ? ((refAcc + refTune) % 64'd4294967296) : refAcc;
      nA    = refLive ? sgn : refA;
      nB    = refLive ? 1 - sgn : refB;
      nLive = 1;
      refTune = nTune; refAcc = nAcc; refA = nA; refB = nB; refLive = nLive;
      liveEdges++;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    vectors++;
    if (clampEnA !== refA[0] || clampEnB !== refB[0]) begin
      miscompares++;
      $display("FAIL %s: enables A=%b B=%b expected A=%0d B=%0d at %0t",
               curReq, clampEnA, clampEnB, refA, refB, $time);
    end
    if (rstN && liveEdges >= 2) begin
      vectors++;
      if (clampEnA === clampEnB) begin
        miscompares++;
        $display("FAIL R2: A=%b B=%b expected complementary", clampEnA, clampEnB);
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic loadWord(logic [31:0] w);
    @(negedge clk);
    tuneWord = w;
    tuneLoad = 1'b1;
    @(negedge clk);
    tuneLoad = 1'b0;
  endtask

  // Measures rising-edge spacing and high time of clampEnA
  task automatic checkPeriod(int cycles, int expPer, string req);
    int lastRise = -1;
    int lastFall = -1;
    logic prevA = clampEnA;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (clampEnA && !prevA) begin
        if (lastRise >= 0) begin
          vectors++;
          if (i - lastRise != expPer) begin
            miscompares++;
            $display("FAIL %s: period %0d expected %0d", req, i - lastRise, expPer);
          end
        end
        lastRise = i;
      end
      if (!clampEnA && prevA && lastRise >= 0) begin
        vectors++;
        if (i - lastRise != expPer / 2) begin
          miscompares++;
          $display("FAIL %s: high time %0d expected %0d", req, i - lastRise, expPer / 2);
        end
        lastFall = i;
      end
      prevA = clampEnA;
    end
    vectors++;
    if (lastFall < 0) begin
      miscompares++;
      $display("FAIL %s: no complete cycle seen, got 0 expected at least 1", req);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    miscompares++;
    $display("FAIL watchdog: run still active, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic heldA;
    // R1: reset state
    curReq = "R1";
    tick(5);
    @(negedge clk); rstN = 1'b1;
    curReq = "R2";
    tick(4);

    // R8: power-of-two word, 32 clock period
    curReq = "R3";
    loadWord(32'h0800_0000);
    checkPeriod(200, 32, "R8");

    // R7: word changes without a strobe are ignored
    curReq = "R7";
    @(negedge clk); tuneWord = 32'h4000_0000;
    checkPeriod(120, 32, "R7");

    // R5: half-scale word toggles every clock
    curReq = "R5";
    loadWord(32'h8000_0000);
    checkPeriod(20, 2, "R8");

    // R6: mid-phase load keeps phase
    curReq = "R6";
    tick(3);
    loadWord(32'h0123_4567);
    tick(300);
    loadWord(32'h1000_0001);
    tick(50);

    // R4: zero word freezes the enables
    curReq = "R4";
    loadWord(32'h0000_0000);
    tick(2);
    heldA = clampEnA;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      vectors++;
      if (clampEnA !== heldA) begin
        miscompares++;
        $display("FAIL R4: A=%b expected frozen %b", clampEnA, heldA);
      end
    end

    // R1: reset in mid-run
    curReq = "R1";
    loadWord(32'h0A00_0000);
    tick(17);
    @(negedge clk); rstN = 1'b0;
    tick(3);
    @(negedge clk); rstN = 1'b1;
    curReq = "R2";
    tick(3);

    // R3: random words and strobes against the reference
    curReq = "R3";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tuneWord = $urandom;
      tuneLoad = (($urandom % 8) == 0);
    end
    @(negedge clk); tuneLoad = 1'b0;
    tick(5);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule